// File: doc/BRIEF.md
# Section-Based Stream Rate Limiter

This block sits in a packet stream and forwards every beat unchanged, but holds the stream back once a per-section budget is spent. Time is cut into sections of a configurable number of clock cycles. Inside a section the stream runs at full rate until the running charge, plus a safety pad, reaches the budget. After that both the output valid and the input ready stay low until the next section begins. A run of consecutive sections forms an interval, and each interval takes its budget from its own entry in a small speed table.

The speed table is written through a simple write port driven by a separate register block. Writing an entry marks it valid. The pointer steps to the next entry at the end of every interval and returns to entry 0 when it reaches the first invalid entry or passes the last entry. The budget is counted either in bytes or in packets. When the block is not running, the stream passes at full speed with no limiting.

Top module: `sect_rate_gate`

## Requirements
- R1: Section timing starts on the first cycle of `run`. A section lasts `sect_len` cycles and an interval lasts `intv_len` sections. Both timing counters are held at zero while `run` is low.
- R2: With limiting active, a handshake can occur in a cycle only while charge + pad + 1 < budget, where charge is the amount already taken in the current section. Once this condition fails, `out_valid` and `in_ready` both stay low until the section ends. The charge returns to zero at the start of every section.
- R3: In byte mode (`pkt_mode` = 0), each accepted beat is charged 8 bytes (the word width). An end-of-packet beat is instead charged `in_epos` + 1, where `in_epos` is the index of the last valid byte. The pad is 3 words, which is 24 bytes.
- R4: In packet mode (`pkt_mode` = 1), each accepted start-of-packet beat is charged 1, and other beats are charged 0. A whole packet therefore counts toward the section in which it started. The pad is 1.
- R5: The charge taken in one section always stays below the budget. A budget at or below pad + 1 lets nothing through.
- R6: At the end of an interval, the pointer moves to the next entry if that entry is valid. Otherwise it returns to entry 0. After entry `N_ENT`-1 it always returns to entry 0.
- R7: A write to a table entry makes that entry valid, and this includes a value of 0. A valid entry of 0 stalls the whole interval. `tbl_inval` clears every valid flag.
- R8: If the entry under the pointer is invalid, no limit applies and the stream runs at full rate.
- R9: While `run` is low, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.
- R10: Dropping `run` leaves the pointer where it is. A `ptr_rst` pulse while stopped returns the pointer to entry 0, and the same pulse is ignored while running.
- R11: Data, start, end and end-position fields pass through unchanged. Each input handshake is exactly one output handshake, so no beat is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Limiting enabled (run mode) |
| pkt_mode | input | 1 | 0: byte budget, 1: packet budget |
| ptr_rst | input | 1 | Return the table pointer to entry 0 (only while stopped) |
| sect_len | input | LEN_W | Section length in cycles |
| intv_len | input | LEN_W | Interval length in sections |
| tbl_wr | input | 1 | Speed table write strobe |
| tbl_idx | input | IDX_W | Speed table write index |
| tbl_val | input | SPD_W | Budget per section for the indexed entry |
| tbl_inval | input | 1 | Clear all entry valid flags |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | DATA_W | Input data word |
| in_sof | input | 1 | Input start of packet |
| in_eof | input | 1 | Input end of packet |
| in_epos | input | EPOS_W | Index of last valid byte on an end beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Output data word |
| out_sof | output | 1 | Output start of packet |
| out_eof | output | 1 | Output end of packet |
| out_epos | output | EPOS_W | Output end position |

## Verification
The bench totals the charge that passes in each section and compares it with the budget of the entry it expects under the pointer. With a full-rate offer the total must be exact: off-by-one pad logic would show up as one word or packet too many or too few, and a tiny budget would leak a beat. The bench also probes where the pointer wraps, both at an unwritten entry and after the last entry. A design that skipped the invalid-entry check or overran the table would apply the wrong budget to the following sections. Finally, the bench stops the block mid-interval and pulses a pointer reset both while running and while stopped. A design that cleared the pointer on stop, or honoured the reset while running, would charge later sections against the wrong entry.

// File: rtl/srl_pkg.sv
package srl_pkg;

  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_PKT  = 1'b1
  } cnt_mode_e;

  // Safety pad added to the running charge before comparison with the budget.
  function automatic int unsigned pad_of(cnt_mode_e mode, int unsigned word_bytes);
    return (mode == MODE_PKT) ? 1 : 3 * word_bytes;
  endfunction

endpackage

// File: rtl/srl_timebase.sv
module srl_timebase #(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [LEN_W-1:0] sect_len,
  input  logic [LEN_W-1:0] intv_len,
  output logic             sect_end,
  output logic             intv_end
);

  logic [LEN_W-1:0] cyc_q;
  logic [LEN_W-1:0] sec_q;
  logic             last_cyc;
  logic             last_sec;

  assign last_cyc = (sect_len <= LEN_W'(1)) || (cyc_q >= sect_len - LEN_W'(1));
  assign last_sec = (intv_len <= LEN_W'(1)) || (sec_q >= intv_len - LEN_W'(1));
  assign sect_end = run && last_cyc;
  assign intv_end = sect_end && last_sec;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cyc_q <= '0;
      sec_q <= '0;
    end else if (sect_end) begin
      cyc_q <= '0;
      sec_q <= last_sec ? '0 : sec_q + LEN_W'(1);
    end else begin
      cyc_q <= cyc_q + LEN_W'(1);
    end
  end

  // R1: a finished section restarts the cycle count
  a_r1_sect_restart: assert property (@(posedge clk) disable iff (rst)
    sect_end |=> (cyc_q == '0));

  // R1: inside a section the cycle count advances by one
  a_r1_cyc_step: assert property (@(posedge clk) disable iff (rst)
    (run && !sect_end) |=> (cyc_q == $past(cyc_q) + LEN_W'(1)));

endmodule

// File: rtl/srl_speed_tbl.sv
module srl_speed_tbl #(
  parameter int N_ENT = 8,
  parameter int IDX_W = $clog2(N_ENT),
  parameter int SPD_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             intv_end,
  input  logic             ptr_rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SPD_W-1:0] wr_val,
  input  logic             inval_all,
  output logic [SPD_W-1:0] budget,
  output logic             cur_vld
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

  logic [SPD_W-1:0] mem [N_ENT];
  logic [N_ENT-1:0] vld_q;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_d;
  logic [IDX_W-1:0] ptr_nxt;

  // Budget storage: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_val;
  end

  always_ff @(posedge clk) begin
    budget <= mem[ptr_d];
  end

  always_ff @(posedge clk) begin
    if (rst || inval_all) vld_q <= '0;
    else if (wr_en)       vld_q[wr_idx] <= 1'b1;
  end

  assign ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + IDX_W'(1);

  always_comb begin
    ptr_d = ptr_q;
    if (run && intv_end)     ptr_d = vld_q[ptr_nxt] ? ptr_nxt : '0;
    else if (!run && ptr_rst) ptr_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_d;
  end

  assign cur_vld = vld_q[ptr_q];

  // R6: an invalid successor sends the pointer back to entry 0
  a_r6_wrap_invalid: assert property (@(posedge clk) disable iff (rst)
    (run && intv_end && !vld_q[ptr_nxt]) |=> (ptr_q == '0));

  // R10: the pointer is held while stopped unless a reset is requested
  a_r10_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !ptr_rst) |=> $stable(ptr_q));

  // R10: a reset request during run has no effect outside an interval end
  a_r10_rst_ignored: assert property (@(posedge clk) disable iff (rst)
    (run && ptr_rst && !intv_end) |=> $stable(ptr_q));

endmodule

// File: rtl/srl_meter.sv
module srl_meter
  import srl_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int EPOS_W = $clog2(DATA_W/8),
  parameter int SPD_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              sect_end,
  input  logic              lim_on,
  input  cnt_mode_e         mode,
  input  logic [SPD_W-1:0]  budget,
  input  logic              xfer,
  input  logic              sof,
  input  logic              eof,
  input  logic [EPOS_W-1:0] epos,
  output logic              open
);

  localparam int WB    = DATA_W / 8;
  localparam int ACC_W = SPD_W + 2;

  logic [ACC_W-1:0] used_q;
  logic [ACC_W-1:0] inc;
  logic [ACC_W-1:0] pad;
  logic [ACC_W:0]   probe;

  assign pad = ACC_W'(pad_of(mode, WB));

  always_comb begin
    if (mode == MODE_PKT) inc = sof ? ACC_W'(1) : '0;
    else if (eof)         inc = ACC_W'(epos) + ACC_W'(1);
    else                  inc = ACC_W'(WB);
  end

  assign probe = {1'b0, used_q} + {1'b0, pad} + (ACC_W+1)'(1);
  assign open  = !run || !lim_on || (probe < (ACC_W+1)'(budget));

  always_ff @(posedge clk) begin
    if (rst || !run || !lim_on || sect_end) used_q <= '0;
    else if (xfer)                          used_q <= used_q + inc;
  end

  // R5: a charged beat never lifts the section total to the budget
  a_r5_under_budget: assert property (@(posedge clk) disable iff (rst)
    (run && lim_on && xfer && !sect_end) |=> (used_q < ACC_W'($past(budget))));

endmodule

// File: rtl/sect_rate_gate.sv
module sect_rate_gate
  import srl_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int EPOS_W = $clog2(DATA_W/8),
  parameter int N_ENT  = 8,
  parameter int IDX_W  = $clog2(N_ENT),
  parameter int SPD_W  = 24,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              pkt_mode,
  input  logic              ptr_rst,
  input  logic [LEN_W-1:0]  sect_len,
  input  logic [LEN_W-1:0]  intv_len,
  input  logic              tbl_wr,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [SPD_W-1:0]  tbl_val,
  input  logic              tbl_inval,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [EPOS_W-1:0] in_epos,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic [EPOS_W-1:0] out_epos
);

  logic             sect_end;
  logic             intv_end;
  logic [SPD_W-1:0] budget;
  logic             cur_vld;
  logic             open;
  logic             xfer;
  cnt_mode_e        mode;

  assign mode = cnt_mode_e'(pkt_mode);

  srl_timebase #(.LEN_W(LEN_W)) u_time (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .sect_len (sect_len),
    .intv_len (intv_len),
    .sect_end (sect_end),
    .intv_end (intv_end)
  );

  srl_speed_tbl #(.N_ENT(N_ENT), .IDX_W(IDX_W), .SPD_W(SPD_W)) u_tbl (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .intv_end  (intv_end),
    .ptr_rst   (ptr_rst),
    .wr_en     (tbl_wr),
    .wr_idx    (tbl_idx),
    .wr_val    (tbl_val),
    .inval_all (tbl_inval),
    .budget    (budget),
    .cur_vld   (cur_vld)
  );

  srl_meter #(.DATA_W(DATA_W), .EPOS_W(EPOS_W), .SPD_W(SPD_W)) u_meter (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .sect_end (sect_end),
    .lim_on   (cur_vld),
    .mode     (mode),
    .budget   (budget),
    .xfer     (xfer),
    .sof      (in_sof),
    .eof      (in_eof),
    .epos     (in_epos),
    .open     (open)
  );

  // Gate both handshake halves together; payload is a straight wire.
  assign out_valid = in_valid && open;
  assign in_ready  = out_ready && open;
  assign xfer      = in_valid && in_ready;
  assign out_data  = in_data;
  assign out_sof   = in_sof;
  assign out_eof   = in_eof;
  assign out_epos  = in_epos;

  // R9: stopped block behaves as a wire on the handshake
  a_r9_bypass: assert property (@(posedge clk) disable iff (rst)
    !run |-> (out_valid == in_valid && in_ready == out_ready));

endmodule

// File: tb/sect_rate_gate_bench.sv
module sect_rate_gate_bench;

  localparam int CLK_PER = 10;
  localparam int DW      = 64;
  localparam int WB      = DW / 8;
  localparam int EW      = 3;
  localparam int NE      = 8;
  localparam int IW      = 3;
  localparam int SW      = 24;
  localparam int LW      = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic          pkt_mode = 1'b0;
  logic          ptr_rst = 1'b0;
  logic [LW-1:0] sect_len = 32'd40;
  logic [LW-1:0] intv_len = 32'd2;
  logic          tbl_wr = 1'b0;
  logic [IW-1:0] tbl_idx = '0;
  logic [SW-1:0] tbl_val = '0;
  logic          tbl_inval = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_sof = 1'b0;
  logic          in_eof = 1'b0;
  logic [EW-1:0] in_epos = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic          out_sof;
  logic          out_eof;
  logic [EW-1:0] out_epos;

  sect_rate_gate u_sect_rate_gate (
    .clk(clk), .rst(rst), .run(run), .pkt_mode(pkt_mode), .ptr_rst(ptr_rst),
    .sect_len(sect_len), .intv_len(intv_len),
    .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .tbl_val(tbl_val), .tbl_inval(tbl_inval),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_epos(in_epos),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_epos(out_epos)
  );

  always #(CLK_PER/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Expected table state, kept from the requirements.
  int unsigned ev [NE];
  bit          evld [NE];
  int          ep = 0;
  int          bc = 0;
  int          bs = 0;
  int          acc = 0;
  bit          took = 1'b0;
  int          gmode = 0;   // 0 random byte, 1 full byte, 2 full single-beat packets
  bit          full = 1'b0;
  int          bl = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pad_b(bit pm);
    return pm ? 1 : 3 * WB;
  endfunction

  // Exact section total under a full-rate offer (R1, R2).
  function automatic int exact_total(int b, bit pm, int sl);
    int u = 0;
    int step = pm ? 1 : WB;
    for (int c = 0; c < sl; c++) if (u + pad_b(pm) + 1 < b) u += step;
    return u;
  endfunction

  function automatic int charge(bit pm, bit s, bit e, int p);
    if (pm) return s ? 1 : 0;
    return e ? p + 1 : WB;
  endfunction

  // Monitor: handshake bookkeeping and per-section checks.
  always @(negedge clk) begin
    if (!rst) begin
      took = in_valid && in_ready;
      if (out_valid) begin
        chk(out_data == in_data && out_sof == in_sof && out_eof == in_eof &&
            out_epos == in_epos, "R11", int'(out_epos), int'(in_epos));
      end
      chk(took == (out_valid && out_ready), "R11", int'(out_valid && out_ready), int'(took));
      if (!run) begin
        chk(out_valid == in_valid && in_ready == out_ready, "R9", int'(in_ready), int'(out_ready));
        bc = 0; bs = 0; acc = 0;
        if (ptr_rst) ep = 0;   // R10: honoured while stopped
      end else begin
        if (took) acc += charge(pkt_mode, in_sof, in_eof, int'(in_epos));
        if (bc == int'(sect_len) - 1) begin
          if (!evld[ep]) begin
            if (full) chk(acc == int'(sect_len) * WB, "R8", acc, int'(sect_len) * WB);
          end else if (int'(ev[ep]) <= pad_b(pkt_mode) + 1) begin
            chk(acc == 0, "R5/R7 tiny budget", acc, 0);
          end else begin
            chk(acc < int'(ev[ep]), "R5", acc, int'(ev[ep]));
            if (full) chk(acc == exact_total(int'(ev[ep]), pkt_mode, int'(sect_len)),
                          pkt_mode ? "R2/R4" : "R2/R3", acc,
                          exact_total(int'(ev[ep]), pkt_mode, int'(sect_len)));
          end
          acc = 0; bc = 0; bs++;
          if (bs >= int'(intv_len)) begin
            int nx;
            bs = 0;
            nx = (ep == NE - 1) ? 0 : ep + 1;
            ep = evld[nx] ? nx : 0;   // R6
          end
        end else begin
          bc++;
        end
      end
    end
  end

  task automatic gen_step();
    if (gmode == 0) begin
      out_ready = ($urandom % 4) != 0;
      if (!in_valid || took) begin
        if ($urandom % 5 == 0) in_valid = 1'b0;
        else begin
          in_valid = 1'b1;
          in_data  = {$urandom, $urandom};
          in_sof   = (bl == 0);
          if (bl == 0) bl = 1 + int'($urandom % 4);
          in_eof   = (bl == 1);
          in_epos  = in_eof ? EW'($urandom % 8) : EW'(7);
          bl--;
        end
      end
    end else if (gmode == 1) begin
      out_ready = 1'b1;
      if (!in_valid || took) begin
        in_valid = 1'b1;
        in_data  = {$urandom, $urandom};
        in_sof   = (bl == 0);
        if (bl == 0) bl = 4;
        in_eof   = (bl == 1);
        in_epos  = EW'(7);
        bl--;
      end
    end else begin
      out_ready = 1'b1;
      if (!in_valid || took) begin
        in_valid = 1'b1;
        in_data  = {$urandom, $urandom};
        in_sof   = 1'b1;
        in_eof   = 1'b1;
        in_epos  = EW'($urandom % 8);
      end
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tbl_wr = 1'b0; tbl_inval = 1'b0; ptr_rst = 1'b0;
      gen_step();
    end
  endtask

  task automatic wr_ent(int i, int unsigned v);
    @(posedge clk); #1;
    tbl_wr = 1'b1; tbl_idx = IW'(i); tbl_val = SW'(v);
    ev[i] = v; evld[i] = 1'b1;
    cycles(1);
  endtask

  task automatic inval_all();
    @(posedge clk); #1;
    tbl_inval = 1'b1;
    for (int i = 0; i < NE; i++) evld[i] = 1'b0;
    cycles(1);
  endtask

  task automatic pulse_prst();
    @(posedge clk); #1;
    ptr_rst = 1'b1;
    gen_step();
    @(posedge clk); #1;
    ptr_rst = 1'b0;
    gen_step();
  endtask

  task automatic start_run(int g, bit f, bit pm);
    @(posedge clk); #1;
    gmode = g; pkt_mode = pm;
    gen_step();
    cycles(3);
    full = f;
    @(posedge clk); #1;
    run = 1'b1;
    gen_step();
  endtask

  task automatic stop_run();
    @(posedge clk); #1;
    run = 1'b0; full = 1'b0;
    gen_step();
    cycles(3);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    for (int i = 0; i < NE; i++) begin ev[i] = 0; evld[i] = 1'b0; end
    in_valid = 1'b1; out_ready = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // Reset state: stopped, handshake is a wire (R9)
    chk(out_valid == 1'b1 && in_ready == 1'b0, "R9 reset", int'(in_ready), 0);

    // Stopped bypass under random traffic (R9, R11)
    gmode = 0;
    cycles(150);

    // Byte budgets; entry 3 left invalid so the loop wraps there (R6, R7)
    inval_all();
    wr_ent(0, 100);
    wr_ent(1, 0);
    wr_ent(2, 60);
    sect_len = 40; intv_len = 2;
    start_run(1, 1'b1, 1'b0);
    cycles(40 * 2 * 7);
    stop_run();

    // Random byte traffic, bound checks only (R3, R5)
    start_run(0, 1'b0, 1'b0);
    cycles(40 * 30 + 23);
    stop_run();   // stops mid-interval; pointer held (R10)

    // Resume with full offer from the held pointer (R10)
    start_run(1, 1'b1, 1'b0);
    cycles(40 * 6 + 11);
    stop_run();

    // Packet mode, all entries valid, wrap after the last one (R4, R6)
    inval_all();
    wr_ent(0, 5);  wr_ent(1, 2);  wr_ent(2, 100); wr_ent(3, 3);
    wr_ent(4, 0);  wr_ent(5, 7);  wr_ent(6, 4);   wr_ent(7, 9);
    sect_len = 40; intv_len = 1;
    pulse_prst();   // R10: honoured while stopped
    start_run(2, 1'b1, 1'b1);
    cycles(40 * 5 + 7);
    pulse_prst();   // R10: ignored while running
    cycles(40 * 12);
    stop_run();
    pulse_prst();
    start_run(2, 1'b1, 1'b1);
    cycles(40 * 4);
    stop_run();

    // Random multi-beat packets in packet mode (R4, R5)
    start_run(0, 1'b0, 1'b1);
    cycles(40 * 16);
    stop_run();

    // No valid entry: no limit (R8)
    inval_all();
    pulse_prst();
    start_run(1, 1'b1, 1'b0);
    cycles(40 * 3);
    stop_run();

    finish_up();
  end

endmodule